// File: doc/BRIEF.md
# Beacon Target Timer Unit

This block keeps a free-running 64-bit microsecond time-sync counter and four 16-bit beacon timers that count in time units (TU, 1024 microseconds). The four timers are the next beacon target, the DMA beacon trigger, the software beacon alert and the end of the announcement (ATIM) window. A single configuration write programs all four timers from one next-beacon value and stores the beacon interval. After that, each timer moves itself forward by one interval on any cycle where the current TU equals its stored value.

A timer only re-arms on an exact TU match. If the counter is loaded with a later time, for example from a received beacon timestamp, a timer that the jump passed stays where it is until the 16-bit TU wraps around to it. The window between two related timers can then grow without any error being raised. A combinational health monitor watches two timer pairs and flags such a drift, so that control logic can reprogram the timers.

Top module: `beacon_timer_unit`

## Requirements
- R1: `tsf_now` resets to 0. It takes `tsf_load_val` on the edge after a cycle with `tsf_load` high, otherwise it grows by 1 after each cycle with `us_tick` high, and otherwise it holds. A load takes priority over a tick in the same cycle.
- R2: `tu_now` equals bits [25:10] of `tsf_now`.
- R3: An accepted configuration write with next-beacon value N sets these values on the following edge: target = N, ATIM end = N+1, software alert = N−10, DMA trigger = N−2, all modulo 2^16. The DMA trigger is presented on `dma_raw` shifted left by 3, with bits [2:0] zero. The same write stores `cfg_interval`.
- R4: `timer_hit` bit i is high while `tu_now` equals timer i. The bit order is [0] target, [1] DMA (its value taken as `dma_raw`>>3), [2] software alert, [3] ATIM end. On the edge that ends such a cycle, that timer grows by the stored interval, modulo 2^16.
- R5: A timer that is not hit and not configured holds its value, even when `tsf_now` is loaded to a TU beyond it. It changes again only when `tu_now` equals it.
- R6: A configuration write in a cycle where a timer is hit loads the configured value, and the interval is not added.
- R7: A write is accepted only if (N − `tu_now`) mod 2^16 ≥ 13. A rejected write changes no timer and no interval, and it raises `cfg_rej` for the following cycle.
- R8: `atim_win_ok` is high when the pair A = target, B = ATIM end, with W = 1 and I = the interval, meets any of these: B−A = W; A−B = I−W; (A+65536)−B = I−W; (B+65536)−A = W. The differences are taken in integer arithmetic.
- R9: `dma_win_ok` applies the R8 rule with A = DMA trigger (in TU), B = target and W = 2.
- R10: `timers_ok` is high exactly when both `atim_win_ok` and `dma_win_ok` are high. The software alert timer has no effect on it.
- R11: While reset is asserted, all timers, the interval, `tsf_now` and `cfg_rej` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | Microsecond tick, advances the counter |
| tsf_load | input | 1 | Overwrite the counter this cycle |
| tsf_load_val | input | 64 | Value for a counter load |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_next_tu | input | 16 | Next beacon time in TU |
| cfg_interval | input | 16 | Beacon interval in TU |
| tsf_now | output | 64 | Current counter value |
| tu_now | output | 16 | Current TU |
| tbtt_tu | output | 16 | Next beacon target timer |
| dma_raw | output | 19 | DMA beacon timer, shifted left by 3 |
| swba_tu | output | 16 | Software beacon alert timer |
| atim_tu | output | 16 | ATIM window end timer |
| timer_hit | output | 4 | Per-timer TU match |
| cfg_rej | output | 1 | Previous configuration write was rejected |
| atim_win_ok | output | 1 | Target/ATIM pair healthy |
| dma_win_ok | output | 1 | DMA/target pair healthy |
| timers_ok | output | 1 | Both pairs healthy |

## Verification
The bench loads the counter so that it skips the ATIM end while the target keeps firing. A design that re-arms on "TU passed" instead of equality would hide the drift, and a monitor without the interval-shifted case would flag the one-sided update as broken too early. A configuration is placed just below the 16-bit TU wrap, so that the target and DMA pairs straddle zero. A monitor that ignores the wrap cases would report a healthy pair as failed there. Further cases are a write on the exact acceptance boundary of 13 TU, a write in a cycle where a timer matches (a wrong priority leaves the value one interval off), and a stranded software alert timer, which must not clear `timers_ok`.

// File: rtl/btu_pkg.sv
package btu_pkg;

  localparam int NUM_TMR = 4;

  typedef enum logic [1:0] {
    TMR_TBTT = 2'd0,
    TMR_DMA  = 2'd1,
    TMR_SWBA = 2'd2,
    TMR_ATIM = 2'd3
  } tmr_id_e;

endpackage

// File: rtl/btu_tsf_counter.sv
module btu_tsf_counter #(
  parameter int TSF_W    = 64,
  parameter int TU_W     = 16,
  parameter int TU_SHIFT = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             us_tick,
  input  logic             tsf_load,
  input  logic [TSF_W-1:0] tsf_load_val,
  output logic [TSF_W-1:0] tsf,
  output logic [TU_W-1:0]  tu
);

  logic [TSF_W-1:0] tsf_nxt;
  logic             tsf_en;

  always_comb begin
    tsf_en  = tsf_load | us_tick;
    tsf_nxt = tsf_load ? tsf_load_val : tsf + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      tsf <= '0;
    else if (tsf_en) tsf <= tsf_nxt;
  end

  assign tu = tsf[TU_SHIFT +: TU_W];

  // R1: a load wins over a tick
  a_r1_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tsf_load |=> tsf == $past(tsf_load_val));
  a_r1_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsf_load && us_tick) |=> tsf == $past(tsf) + 1'b1);
  a_r1_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tsf_load && !us_tick) |=> $stable(tsf));

endmodule

// File: rtl/btu_timer_slot.sv
module btu_timer_slot #(
  parameter int TU_W = 16,
  parameter int SH   = 0,
  localparam int VW  = TU_W + SH
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TU_W-1:0] tu,
  input  logic            cfg_en,
  input  logic [TU_W-1:0] cfg_tu,
  input  logic [TU_W-1:0] step,
  output logic [VW-1:0]   value,
  output logic            hit
);

  logic [VW-1:0] value_nxt;
  logic          value_en;

  always_comb begin
    hit       = (value[VW-1:SH] == tu);
    value_en  = cfg_en | hit;
    value_nxt = cfg_en ? (VW'(cfg_tu) << SH) : value + (VW'(step) << SH);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value <= '0;
    else if (value_en) value <= value_nxt;
  end

  // R6: a configuration overrides a re-arm in the same cycle
  a_r6_cfg_overrides: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_en |=> value == $past(VW'(cfg_tu) << SH));
  // R4: a TU match advances the timer by one interval
  a_r4_rearm_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && hit) |=> value == $past(value + (VW'(step) << SH)));
  // R5: no match and no configuration means no change
  a_r5_stale_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !hit) |=> $stable(value));

endmodule

// File: rtl/btu_window_check.sv
module btu_window_check #(
  parameter int TU_W = 16
) (
  input  logic [TU_W-1:0] a_tu,
  input  logic [TU_W-1:0] b_tu,
  input  logic [TU_W-1:0] interval,
  input  logic [TU_W-1:0] window,
  output logic            ok
);

  localparam int SW = TU_W + 3;

  logic signed [SW-1:0] ax, bx, ix, wx, wrap, gap;

  always_comb begin
    ax   = $signed({3'b000, a_tu});
    bx   = $signed({3'b000, b_tu});
    ix   = $signed({3'b000, interval});
    wx   = $signed({3'b000, window});
    wrap = $signed({3'b001, {TU_W{1'b0}}});
    gap  = ix - wx;
    ok   = ((bx - ax) == wx)
        || ((ax - bx) == gap)
        || ((ax + wrap - bx) == gap)
        || ((bx + wrap - ax) == wx);
  end

endmodule

// File: rtl/beacon_timer_unit.sv
module beacon_timer_unit
  import btu_pkg::*;
#(
  parameter int TSF_W      = 64,
  parameter int TU_W       = 16,
  parameter int TU_SHIFT   = 10,
  parameter int DMA_SH     = 3,
  parameter int SW_RESP    = 10,
  parameter int DMA_RESP   = 2,
  parameter int LEAD_EXTRA = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   us_tick,
  input  logic                   tsf_load,
  input  logic [TSF_W-1:0]       tsf_load_val,
  input  logic                   cfg_wr,
  input  logic [TU_W-1:0]        cfg_next_tu,
  input  logic [TU_W-1:0]        cfg_interval,
  output logic [TSF_W-1:0]       tsf_now,
  output logic [TU_W-1:0]        tu_now,
  output logic [TU_W-1:0]        tbtt_tu,
  output logic [TU_W+DMA_SH-1:0] dma_raw,
  output logic [TU_W-1:0]        swba_tu,
  output logic [TU_W-1:0]        atim_tu,
  output logic [NUM_TMR-1:0]     timer_hit,
  output logic                   cfg_rej,
  output logic                   atim_win_ok,
  output logic                   dma_win_ok,
  output logic                   timers_ok
);

  localparam int LEAD   = SW_RESP + LEAD_EXTRA;
  localparam int VW     = TU_W + DMA_SH;
  localparam int I_TBTT = int'(TMR_TBTT);
  localparam int I_DMA  = int'(TMR_DMA);
  localparam int I_SWBA = int'(TMR_SWBA);
  localparam int I_ATIM = int'(TMR_ATIM);

  logic [NUM_TMR-1:0][TU_W-1:0] cfg_vec;
  logic [NUM_TMR-1:0][TU_W-1:0] tmr_tu;
  logic [VW-1:0]                dma_val;
  logic [TU_W-1:0]              interval_q;
  logic [TU_W-1:0]              cfg_lead;
  logic                         cfg_ok;
  logic                         rej_nxt;

  btu_tsf_counter #(.TSF_W(TSF_W), .TU_W(TU_W), .TU_SHIFT(TU_SHIFT)) u_tsf (
    .clk          (clk),
    .rst_n        (rst_n),
    .us_tick      (us_tick),
    .tsf_load     (tsf_load),
    .tsf_load_val (tsf_load_val),
    .tsf          (tsf_now),
    .tu           (tu_now)
  );

  // configuration acceptance and derived per-timer values
  always_comb begin
    cfg_lead        = cfg_next_tu - tu_now;
    cfg_ok          = cfg_wr && (cfg_lead >= TU_W'(LEAD));
    rej_nxt         = cfg_wr && !cfg_ok;
    cfg_vec[I_TBTT] = cfg_next_tu;
    cfg_vec[I_DMA]  = cfg_next_tu - TU_W'(DMA_RESP);
    cfg_vec[I_SWBA] = cfg_next_tu - TU_W'(SW_RESP);
    cfg_vec[I_ATIM] = cfg_next_tu + TU_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      interval_q <= '0;
      cfg_rej    <= 1'b0;
    end else begin
      if (cfg_ok) interval_q <= cfg_interval;
      cfg_rej <= rej_nxt;
    end
  end

  for (genvar gi = 0; gi < NUM_TMR; gi++) begin : g_tmr
    if (gi == I_DMA) begin : g_shifted
      btu_timer_slot #(.TU_W(TU_W), .SH(DMA_SH)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .tu     (tu_now),
        .cfg_en (cfg_ok),
        .cfg_tu (cfg_vec[gi]),
        .step   (interval_q),
        .value  (dma_val),
        .hit    (timer_hit[gi])
      );
      assign tmr_tu[gi] = dma_val[VW-1:DMA_SH];
    end else begin : g_plain
      btu_timer_slot #(.TU_W(TU_W), .SH(0)) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .tu     (tu_now),
        .cfg_en (cfg_ok),
        .cfg_tu (cfg_vec[gi]),
        .step   (interval_q),
        .value  (tmr_tu[gi]),
        .hit    (timer_hit[gi])
      );
    end
  end

  assign tbtt_tu = tmr_tu[I_TBTT];
  assign dma_raw = dma_val;
  assign swba_tu = tmr_tu[I_SWBA];
  assign atim_tu = tmr_tu[I_ATIM];

  btu_window_check #(.TU_W(TU_W)) u_win_atim (
    .a_tu     (tmr_tu[I_TBTT]),
    .b_tu     (tmr_tu[I_ATIM]),
    .interval (interval_q),
    .window   (TU_W'(1)),
    .ok       (atim_win_ok)
  );

  btu_window_check #(.TU_W(TU_W)) u_win_dma (
    .a_tu     (tmr_tu[I_DMA]),
    .b_tu     (tmr_tu[I_TBTT]),
    .interval (interval_q),
    .window   (TU_W'(DMA_RESP)),
    .ok       (dma_win_ok)
  );

  assign timers_ok = atim_win_ok & dma_win_ok;

  // R7: a rejected write leaves the interval and flags itself
  a_r7_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && !cfg_ok) |=> cfg_rej && $stable(interval_q));
  // R3: a freshly accepted configuration is always healthy
  a_r3_fresh_healthy: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ok |=> timers_ok);
  // R3: shifted timer never carries low bits
  a_r3_dma_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dma_raw[DMA_SH-1:0] == '0);

endmodule

// File: tb/beacon_timer_unit_tb.sv
`timescale 1ns/1ps
module beacon_timer_unit_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        us_tick, tsf_load, cfg_wr;
  logic [63:0] tsf_load_val;
  logic [15:0] cfg_next_tu, cfg_interval;
  logic [63:0] tsf_now;
  logic [15:0] tu_now, tbtt_tu, swba_tu, atim_tu;
  logic [18:0] dma_raw;
  logic [3:0]  timer_hit;
  logic        cfg_rej, atim_win_ok, dma_win_ok, timers_ok;

  always #2 clk = ~clk;

  beacon_timer_unit u_dut (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .tsf_load(tsf_load),
    .tsf_load_val(tsf_load_val), .cfg_wr(cfg_wr), .cfg_next_tu(cfg_next_tu),
    .cfg_interval(cfg_interval), .tsf_now(tsf_now), .tu_now(tu_now),
    .tbtt_tu(tbtt_tu), .dma_raw(dma_raw), .swba_tu(swba_tu), .atim_tu(atim_tu),
    .timer_hit(timer_hit), .cfg_rej(cfg_rej), .atim_win_ok(atim_win_ok),
    .dma_win_ok(dma_win_ok), .timers_ok(timers_ok)
  );

  int total = 0;
  int bad   = 0;
  int cyc_cnt = 0;
  bit finished = 0;

  // reference model state: counter, timers in TU (0 target,1 dma,2 alert,3 atim)
  longint unsigned m_tsf;
  int m_tmr[4];
  int m_int;
  bit m_rej;

  function automatic int tu_of(longint unsigned t);
    return int'((t >> 10) & 64'hFFFF);
  endfunction

  function automatic bit pair_ok(int a, int b, int w, int i);
    return (b - a == w) || (a - b == i - w) ||
           ((a | 'h10000) - b == i - w) || ((b | 'h10000) - a == w);
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tsf = 0; m_int = 0; m_rej = 0;
      for (int i = 0; i < 4; i++) m_tmr[i] = 0;
    end else begin
      int tu;
      bit acc;
      tu  = tu_of(m_tsf);
      acc = cfg_wr && (((int'(cfg_next_tu) - tu) & 'hFFFF) >= 13);
      if (acc) begin
        m_tmr[0] = int'(cfg_next_tu);
        m_tmr[1] = (int'(cfg_next_tu) - 2) & 'hFFFF;
        m_tmr[2] = (int'(cfg_next_tu) - 10) & 'hFFFF;
        m_tmr[3] = (int'(cfg_next_tu) + 1) & 'hFFFF;
        m_int    = int'(cfg_interval);
      end else begin
        for (int i = 0; i < 4; i++)
          if (m_tmr[i] == tu) m_tmr[i] = (m_tmr[i] + m_int) & 'hFFFF;
      end
      m_rej = cfg_wr && !acc;
      if (tsf_load)     m_tsf = tsf_load_val;
      else if (us_tick) m_tsf = m_tsf + 1;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit aok, dok;
      int tu;
      tu  = tu_of(m_tsf);
      aok = pair_ok(m_tmr[0], m_tmr[3], 1, m_int);
      dok = pair_ok(m_tmr[1], m_tmr[0], 2, m_int);
      chk("R1 tsf_now", tsf_now, m_tsf);
      chk("R2 tu_now", tu_now, tu);
      chk("R4 tbtt_tu", tbtt_tu, m_tmr[0]);
      chk("R4 dma_raw", dma_raw, m_tmr[1] << 3);
      chk("R5 swba_tu", swba_tu, m_tmr[2]);
      chk("R5 atim_tu", atim_tu, m_tmr[3]);
      for (int i = 0; i < 4; i++)
        chk("R4 timer_hit", timer_hit[i], (m_tmr[i] == tu));
      chk("R7 cfg_rej", cfg_rej, m_rej);
      chk("R8 atim_win_ok", atim_win_ok, aok);
      chk("R9 dma_win_ok", dma_win_ok, dok);
      chk("R10 timers_ok", timers_ok, aok && dok);
    end
  end

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 190000 && !finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<190000", cyc_cnt);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic load_tsf(longint unsigned v);
    tsf_load = 1'b1; tsf_load_val = v;
    cyc();
    tsf_load = 1'b0;
  endtask

  task automatic write_cfg(int nxt, int iv);
    cfg_wr = 1'b1; cfg_next_tu = 16'(nxt); cfg_interval = 16'(iv);
    cyc();
    cfg_wr = 1'b0;
  endtask

  task automatic run_to_tu(int t);
    while (int'(tu_now) != t && !finished) cyc();
  endtask

  task automatic probe(string tag, longint act, longint exp);
    @(negedge clk);
    chk(tag, act, exp);
    #1;
  endtask

  initial begin
    longint unsigned hold;
    rst_n = 1'b0; us_tick = 1'b0; tsf_load = 1'b0; cfg_wr = 1'b0;
    tsf_load_val = '0; cfg_next_tu = '0; cfg_interval = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset values
    chk("R11 tsf_now", tsf_now, 0);
    chk("R11 tbtt_tu", tbtt_tu, 0);
    chk("R11 dma_raw", dma_raw, 0);
    chk("R11 swba_tu", swba_tu, 0);
    chk("R11 atim_tu", atim_tu, 0);
    chk("R11 cfg_rej", cfg_rej, 0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R1: ticking, then gated, then load beating a tick
    us_tick = 1'b1;
    repeat (5) cyc();
    us_tick = 1'b0;
    hold = tsf_now;
    repeat (3) cyc();
    probe("R1 gated hold", tsf_now, hold);
    us_tick = 1'b1;
    load_tsf(64'(99 * 1024));
    probe("R1 load priority", tsf_now, 99 * 1024);

    // R7: lead below and at the margin
    write_cfg(111, 4);
    probe("R7 reject flag", cfg_rej, 1);
    probe("R7 reject no change", tbtt_tu, 0);
    write_cfg(112, 4);
    probe("R3 target", tbtt_tu, 112);
    probe("R3 atim end", atim_tu, 113);
    probe("R3 soft alert", swba_tu, 102);
    probe("R3 dma shifted", dma_raw, 110 << 3);
    run_to_tu(120);
    probe("R10 healthy run", timers_ok, 1);

    // R5/R8: skip the ATIM end while the target keeps firing
    write_cfg(140, 10);
    load_tsf(64'(140 * 1024));
    load_tsf(64'(142 * 1024));
    probe("R8 one-sided update ok", atim_win_ok, 1);
    run_to_tu(151);
    probe("R5 atim stale", atim_tu, 141);
    probe("R8 drift detected", atim_win_ok, 0);
    probe("R10 drift not ok", timers_ok, 0);

    // R6: configuration while the target is hit
    load_tsf(64'(160 * 1024));
    probe("R6 hit present", timer_hit[0], 1);
    write_cfg(180, 10);
    probe("R6 cfg wins", tbtt_tu, 180);

    // R10: stranded software alert does not matter
    load_tsf(64'(175 * 1024));
    run_to_tu(182);
    probe("R10 alert stale", swba_tu, 170);
    probe("R10 alert excluded", timers_ok, 1);

    // R8/R9: pairs straddling the TU wrap
    load_tsf(64'(65510) * 1024);
    write_cfg(65535, 7);
    probe("R3 atim wraps", atim_tu, 0);
    probe("R8 wrap pair ok", atim_win_ok, 1);
    run_to_tu(65534);
    probe("R9 dma wrapped early", dma_win_ok, 1);
    run_to_tu(2);
    probe("R4 target wrapped", tbtt_tu, 6);
    probe("R10 after wrap", timers_ok, 1);

    repeat (4) cyc();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule